// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block holds the interrupt state for one group of up to 32 interrupt sources. Hardware event inputs latch into a cause register. Software reads and clears the latched state through a simple register port. Software also chooses, separately for each bit and at run time, how that bit is cleared: either by writing a 1 to it, or as a side effect of reading it.

A mask register hides selected causes from a masked-cause view. The mask can be written whole, or updated through separate set and clear strobes, so that software never needs a read-modify-write sequence. The block drives one interrupt line. That line is a registered OR of every unmasked cause bit.

The port is a single-cycle read/write interface. Read data is combinational while the read strobe is high. Any clear caused by that read takes effect at the same clock edge. A given interrupt uses the same bit position in every register of the bank.

Top module: `irq_cause_bank`

## Requirements
- R1: After reset, the mode, cause and mask registers are all zero, irqOut is 0, and every readable offset returns zero.
- R2: Word registers decode at these byte offsets:
  - mode select at 0x00 (bit value 0 = clear by writing 1, 1 = clear on read)
  - cause at 0x04
  - masked cause at 0x08
  - cause set at 0x0C
  - mask value at 0x10
  - mask set at 0x14
  - mask clear at 0x18

  Reads of 0x0C, 0x14, 0x18 and 0x1C return zero. Writes to 0x1C, and any access whose address bits [1:0] are not zero, change nothing.
- R3: A 1 on a bit of hwEvent sets the matching cause bit at the next clock edge. The bit stays set until it is cleared.
- R4: For a bit in write-1 mode (mode bit 0), writing a 1 at offset 0x04 clears it. Writing 0 leaves it set, and reading does not clear it.
- R5: For a bit in clear-on-read mode (mode bit 1), a read of offset 0x04 returns the bit and clears it at that edge. Writing a 1 to it has no effect.
- R6: Offset 0x08 reads as cause AND NOT mask. A read there in clear-on-read mode, or a write of 1 there in write-1 mode, clears only cause bits that are unmasked.
- R7: Writing a 1 to a bit at offset 0x0C sets that cause bit.
- R8: At 0x14, a 1 sets the matching mask bit. At 0x18, a 1 clears it. Offset 0x10 reads the mask and writes it directly. Bits written as 0 at 0x14 or 0x18 keep their value.
- R9: When a set (event or cause-set write) and a clear of the same cause bit happen in the same cycle, the bit ends up set.
- R10: irqOut equals the OR of all masked-cause bits one clock cycle earlier.
- R11: The clear mode is chosen per bit. A single read of 0x04 clears the clear-on-read bits and leaves the write-1 bits of the same register set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W (5) | Byte address of the register access |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | WIDTH (32) | Write data |
| regRdEn | input | 1 | Read strobe; clear-on-read acts at the edge ending it |
| regRdData | output | WIDTH (32) | Combinational read data, zero when no read |
| hwEvent | input | WIDTH (32) | Per-bit hardware event inputs, active high |
| irqOut | output | 1 | Registered interrupt request |

## Verification
The clear mechanism is tried with all bits in write-1 mode, with all bits in clear-on-read mode, and with a register that mixes the two. The mixed case separates a per-bit mode decode from a global one. The masked view is driven through whole, set and clear mask writes, and then cleared both by write and by read. This shows that clears through offset 0x08 spare masked bits. Collision cycles, where an event lands on the same cycle as a write-1 clear or a clearing read, show whether set has priority. Pulsing a single event and then toggling its mask pins the one-cycle lag of irqOut.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  // Word index of each register (byte offset / 4)
  localparam int IDX_MODE      = 0;
  localparam int IDX_CAUSE     = 1;
  localparam int IDX_MASKED    = 2;
  localparam int IDX_CAUSE_SET = 3;
  localparam int IDX_MASK_VAL  = 4;
  localparam int IDX_MASK_SET  = 5;
  localparam int IDX_MASK_CLR  = 6;

  typedef enum logic [2:0] {
    SEL_ZERO,
    SEL_MODE,
    SEL_CAUSE,
    SEL_MASKED,
    SEL_MASK
  } rdSel_e;

  typedef struct packed {
    logic   wrMode;
    logic   wrCause;
    logic   wrMasked;
    logic   wrSet;
    logic   wrMaskVal;
    logic   wrMaskSet;
    logic   wrMaskClr;
    logic   rdCause;
    logic   rdMasked;
    rdSel_e rdSel;
  } bankStrobes_t;

endpackage

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  output bankStrobes_t      strobes
);

  localparam int IDX_W = ADDR_W - 2;

  logic             aligned;
  logic [IDX_W-1:0] wordIdx;
  logic             wrOk;
  logic             rdOk;

  assign aligned = (regAddr[1:0] == 2'b00);
  assign wordIdx = regAddr[ADDR_W-1:2];
  assign wrOk    = regWrEn && aligned;
  assign rdOk    = regRdEn && aligned;

  always_comb begin
    strobes           = '0;
    strobes.rdSel     = SEL_ZERO;
    strobes.wrMode    = wrOk && (wordIdx == IDX_W'(IDX_MODE));
    strobes.wrCause   = wrOk && (wordIdx == IDX_W'(IDX_CAUSE));
    strobes.wrMasked  = wrOk && (wordIdx == IDX_W'(IDX_MASKED));
    strobes.wrSet     = wrOk && (wordIdx == IDX_W'(IDX_CAUSE_SET));
    strobes.wrMaskVal = wrOk && (wordIdx == IDX_W'(IDX_MASK_VAL));
    strobes.wrMaskSet = wrOk && (wordIdx == IDX_W'(IDX_MASK_SET));
    strobes.wrMaskClr = wrOk && (wordIdx == IDX_W'(IDX_MASK_CLR));
    strobes.rdCause   = rdOk && (wordIdx == IDX_W'(IDX_CAUSE));
    strobes.rdMasked  = rdOk && (wordIdx == IDX_W'(IDX_MASKED));
    if (rdOk) begin
      if (wordIdx == IDX_W'(IDX_MODE))          strobes.rdSel = SEL_MODE;
      else if (wordIdx == IDX_W'(IDX_CAUSE))    strobes.rdSel = SEL_CAUSE;
      else if (wordIdx == IDX_W'(IDX_MASKED))   strobes.rdSel = SEL_MASKED;
      else if (wordIdx == IDX_W'(IDX_MASK_VAL)) strobes.rdSel = SEL_MASK;
    end
  end

endmodule

// File: rtl/irq_bank_dp.sv
module irq_bank_dp
  import irq_bank_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bankStrobes_t     strobes,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] hwEvent,
  output logic [WIDTH-1:0] rdData,
  output logic             irqOut,
  output logic [WIDTH-1:0] modeQ,
  output logic [WIDTH-1:0] causeQ,
  output logic [WIDTH-1:0] maskQ
);

  logic [WIDTH-1:0] maskedView;
  logic [WIDTH-1:0] causeNext;
  logic [WIDTH-1:0] maskNext;
  logic             irqQ;

  assign maskedView = causeQ & ~maskQ;

  // Per-bit cause update; a set always overrides a clear in the same cycle
  for (genvar i = 0; i < WIDTH; i++) begin : gBit
    logic wrClr;
    logic rdClr;
    logic setBit;
    assign wrClr  = ~modeQ[i] & wrData[i] &
                    (strobes.wrCause | (strobes.wrMasked & ~maskQ[i]));
    assign rdClr  = modeQ[i] &
                    ((strobes.rdCause & causeQ[i]) | (strobes.rdMasked & maskedView[i]));
    assign setBit = hwEvent[i] | (strobes.wrSet & wrData[i]);
    assign causeNext[i] = setBit | (causeQ[i] & ~(wrClr | rdClr));
  end

  always_comb begin
    maskNext = maskQ;
    if (strobes.wrMaskVal)      maskNext = wrData;
    else if (strobes.wrMaskSet) maskNext = maskQ | wrData;
    else if (strobes.wrMaskClr) maskNext = maskQ & ~wrData;
  end

  always_comb begin
    unique case (strobes.rdSel)
      SEL_MODE:   rdData = modeQ;
      SEL_CAUSE:  rdData = causeQ;
      SEL_MASKED: rdData = maskedView;
      SEL_MASK:   rdData = maskQ;
      default:    rdData = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeQ  <= '0;
      causeQ <= '0;
      maskQ  <= '0;
      irqQ   <= 1'b0;
    end else begin
      if (strobes.wrMode) modeQ <= wrData;
      causeQ <= causeNext;
      maskQ  <= maskNext;
      irqQ   <= |maskedView;
    end
  end

  assign irqOut = irqQ;

endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
  import irq_bank_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [WIDTH-1:0]  regWrData,
  input  logic              regRdEn,
  output logic [WIDTH-1:0]  regRdData,
  input  logic [WIDTH-1:0]  hwEvent,
  output logic              irqOut
);

  bankStrobes_t     strobes;
  logic [WIDTH-1:0] modeQ;
  logic [WIDTH-1:0] causeQ;
  logic [WIDTH-1:0] maskQ;

  irq_bank_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .strobes (strobes)
  );

  irq_bank_dp #(.WIDTH(WIDTH)) uDp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .wrData  (regWrData),
    .hwEvent (hwEvent),
    .rdData  (regRdData),
    .irqOut  (irqOut),
    .modeQ   (modeQ),
    .causeQ  (causeQ),
    .maskQ   (maskQ)
  );

endmodule

// File: rtl/irq_bank_checker.sv
module irq_bank_checker #(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [WIDTH-1:0]  regWrData,
  input logic              regRdEn,
  input logic [WIDTH-1:0]  hwEvent,
  input logic              irqOut,
  input logic [WIDTH-1:0]  modeQ,
  input logic [WIDTH-1:0]  causeQ,
  input logic [WIDTH-1:0]  maskQ
);

  logic wrSetHit, wrMaskSetHit, wrMaskClrHit, rdCauseHit;
  assign wrSetHit     = regWrEn && (regAddr == ADDR_W'(12));
  assign wrMaskSetHit = regWrEn && (regAddr == ADDR_W'(20));
  assign wrMaskClrHit = regWrEn && (regAddr == ADDR_W'(24));
  assign rdCauseHit   = regRdEn && !regWrEn && (regAddr == ADDR_W'(4)) && (hwEvent == '0);

  a_r3_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (hwEvent != '0) |=> ((causeQ & $past(hwEvent)) == $past(hwEvent)));

  a_r7_set_write: assert property (@(posedge clk) disable iff (!rst_n)
    wrSetHit |=> ((causeQ & $past(regWrData)) == $past(regWrData)));

  a_r8_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    wrMaskSetHit |=> ((maskQ & $past(regWrData)) == $past(regWrData)));

  a_r8_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
    wrMaskClrHit |=> ((maskQ & $past(regWrData)) == '0));

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rdCauseHit |=> ((causeQ & $past(causeQ & modeQ)) == '0));

  a_r10_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irqOut == $past(|(causeQ & ~maskQ))));

endmodule

bind irq_cause_bank irq_bank_checker #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .regRdEn   (regRdEn),
  .hwEvent   (hwEvent),
  .irqOut    (irqOut),
  .modeQ     (modeQ),
  .causeQ    (causeQ),
  .maskQ     (maskQ)
);

// File: tb/sim_irq_cause_bank.sv
`timescale 1ns/1ps
module sim_irq_cause_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic        regRdEn = 1'b0;
  logic [31:0] regRdData;
  logic [31:0] hwEvent = '0;
  logic        irqOut;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  irq_cause_bank u0 (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .hwEvent(hwEvent), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wrReg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic pulseEvent(input logic [31:0] v);
    @(negedge clk);
    hwEvent = v;
    @(negedge clk);
    hwEvent = '0;
  endtask

  task automatic clearAll();
    wrReg(5'h00, 32'h0);
    wrReg(5'h10, 32'h0);
    wrReg(5'h04, 32'hFFFF_FFFF);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irqOut", {31'b0, irqOut}, 32'h0);
    for (int a = 0; a < 8; a++) begin
      rdReg(5'(a * 4), d);
      check("R1 reset readback", d, 32'h0);
    end
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    clearAll();
    pulseEvent(32'h0000_00F0);
    rdReg(5'h04, d); check("R3 event latched", d, 32'h0000_00F0);
    rdReg(5'h04, d); check("R4 read keeps bits", d, 32'h0000_00F0);
    wrReg(5'h04, 32'h0000_0030);
    rdReg(5'h04, d); check("R4 write-1 clears", d, 32'h0000_00C0);
    wrReg(5'h04, 32'h0);
    rdReg(5'h04, d); check("R4 write-0 no effect", d, 32'h0000_00C0);
  endtask

  task automatic t_cor();
    logic [31:0] d;
    clearAll();
    wrReg(5'h00, 32'hFFFF_FFFF);
    rdReg(5'h00, d); check("R2 mode readback", d, 32'hFFFF_FFFF);
    pulseEvent(32'h0000_0F00);
    wrReg(5'h04, 32'h0000_0F00);
    rdReg(5'h04, d); check("R5 write ignored, read returns", d, 32'h0000_0F00);
    rdReg(5'h04, d); check("R5 read cleared", d, 32'h0);
  endtask

  task automatic t_mixed();
    logic [31:0] d;
    clearAll();
    wrReg(5'h00, 32'h0000_00FF);
    pulseEvent(32'h0000_0101);
    rdReg(5'h04, d); check("R11 first read", d, 32'h0000_0101);
    rdReg(5'h04, d); check("R11 only read-mode bit cleared", d, 32'h0000_0100);
    wrReg(5'h04, 32'h0000_0100);
    rdReg(5'h04, d); check("R11 write-1 bit cleared", d, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    clearAll();
    wrReg(5'h0C, 32'h0000_000F);
    rdReg(5'h04, d); check("R7 cause set", d, 32'h0000_000F);
    wrReg(5'h10, 32'h0000_0003);
    rdReg(5'h10, d); check("R8 mask value", d, 32'h0000_0003);
    rdReg(5'h08, d); check("R6 masked view", d, 32'h0000_000C);
    wrReg(5'h14, 32'h0000_0004);
    rdReg(5'h10, d); check("R8 mask set", d, 32'h0000_0007);
    wrReg(5'h18, 32'h0000_0001);
    rdReg(5'h10, d); check("R8 mask clear", d, 32'h0000_0006);
    rdReg(5'h08, d); check("R6 masked after clear", d, 32'h0000_0009);
    wrReg(5'h08, 32'h0000_000F);
    rdReg(5'h04, d); check("R6 masked write spares masked bits", d, 32'h0000_0006);
    wrReg(5'h00, 32'hFFFF_FFFF);
    wrReg(5'h0C, 32'h0000_0001);
    rdReg(5'h08, d); check("R6 masked read value", d, 32'h0000_0001);
    rdReg(5'h04, d); check("R6 masked read spares masked bits", d, 32'h0000_0006);
  endtask

  task automatic t_irq();
    clearAll();
    @(negedge clk);
    check("R10 idle irq", {31'b0, irqOut}, 32'h0);
    pulseEvent(32'h8000_0000);
    check("R10 irq not yet", {31'b0, irqOut}, 32'h0);
    @(negedge clk);
    check("R10 irq one cycle later", {31'b0, irqOut}, 32'h1);
    wrReg(5'h14, 32'h8000_0000);
    @(negedge clk);
    check("R10 masked irq drops", {31'b0, irqOut}, 32'h0);
    wrReg(5'h18, 32'h8000_0000);
    @(negedge clk);
    check("R10 unmask irq returns", {31'b0, irqOut}, 32'h1);
    wrReg(5'h04, 32'h8000_0000);
    @(negedge clk);
    check("R10 irq after clear", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_setwins();
    logic [31:0] d;
    clearAll();
    wrReg(5'h0C, 32'h0000_0004);
    @(negedge clk);
    regAddr = 5'h04; regWrData = 32'h0000_0004; regWrEn = 1'b1; hwEvent = 32'h0000_0004;
    @(negedge clk);
    regWrEn = 1'b0; hwEvent = '0;
    rdReg(5'h04, d); check("R9 event beats write clear", d, 32'h0000_0004);
    clearAll();
    wrReg(5'h00, 32'h0000_0020);
    wrReg(5'h0C, 32'h0000_0020);
    @(negedge clk);
    regAddr = 5'h04; regRdEn = 1'b1; hwEvent = 32'h0000_0020;
    #1 d = regRdData;
    check("R9 collision read value", d, 32'h0000_0020);
    @(negedge clk);
    regRdEn = 1'b0; hwEvent = '0;
    rdReg(5'h04, d); check("R9 event beats read clear", d, 32'h0000_0020);
    rdReg(5'h04, d); check("R9 later read clears", d, 32'h0);
  endtask

  task automatic t_addr();
    logic [31:0] d;
    clearAll();
    wrReg(5'h1C, 32'hFFFF_FFFF);
    wrReg(5'h05, 32'hFFFF_FFFF);
    wrReg(5'h0D, 32'hFFFF_FFFF);
    rdReg(5'h00, d); check("R2 unused write no mode change", d, 32'h0);
    rdReg(5'h04, d); check("R2 unused write no cause change", d, 32'h0);
    rdReg(5'h10, d); check("R2 unused write no mask change", d, 32'h0);
    wrReg(5'h14, 32'h0000_1000);
    rdReg(5'h14, d); check("R2 mask set reads zero", d, 32'h0);
    rdReg(5'h18, d); check("R2 mask clear reads zero", d, 32'h0);
    wrReg(5'h0C, 32'h0000_0002);
    rdReg(5'h0C, d); check("R2 cause set reads zero", d, 32'h0);
    rdReg(5'h1C, d); check("R2 unused reads zero", d, 32'h0);
    rdReg(5'h11, d); check("R2 misaligned read zero", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_w1c();
    t_cor();
    t_mixed();
    t_mask();
    t_irq();
    t_setwins();
    t_addr();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule